// File: doc/BRIEF.md
# Command-Driven DMA Channel

This block is one DMA channel. It takes a transfer descriptor made of a 32-bit command word, a source address and a target address. The byte count lives in the low bits of the command word. The channel then moves the data over a simple bus master port, one beat at a time. Each step is a read beat followed by a write beat that carries the data just read. The command word chooses three things:

- whether each address steps forward or stays fixed, for FIFO or I/O endpoints;
- whether a peripheral request line paces each step, and which side owns that request;
- which interrupt events are recorded.

The channel keeps three sticky status flags: descriptor accepted, transfer finished and illegal command. A flag is cleared by writing 1 to its bit of the clear input. The interrupt output is high while any flag is set. A descriptor is offered with a valid/ready handshake. The channel accepts a descriptor only while it is idle.

Top module: `dma_cmd_channel`

## Requirements
- R1: After reset the channel is idle: `busy`=0, `desc_ready`=1, `bus_req`=0, all three status flags are 0 and `irq`=0.
- R2: A descriptor is taken on a clock edge where `desc_valid` and `desc_ready` are both 1. `desc_ready` stays 0 while `busy` is 1, and `busy` is 1 from the cycle after acceptance until the transfer ends.
- R3: When command bit 31 is 1, the source address advances by the beat size (DW/8 bytes) after each read/write pair. When bit 31 is 0, every read uses the address that was loaded.
- R4: Command bit 30 controls the target address in the same way that bit 31 controls the source address.
- R5: Each step drives a read (`bus_req`=1, `bus_we`=0) at the source address until `bus_ack` is seen. It then drives a write (`bus_we`=1) at the target address, with `bus_wdata` equal to the data read. Address and request stay stable while `bus_ack` is 0.
- R6: When command bit 29 (source pacing) or bit 28 (target pacing) is 1, each read beat starts only after `dreq` has been sampled high in the wait cycle. When both bits are 0, the read starts in the cycle after the wait cycle with no regard to `dreq`.
- R7: A descriptor with bits 29 and 28 both 1 causes no bus activity. The channel stays idle and the error flag `st_err` becomes 1.
- R8: When command bit 22 is 1, `st_start` becomes 1 in the cycle after a legal descriptor is accepted.
- R9: The byte count is command bits 12:0. It drops by DW/8 after each write ack and saturates at zero. When the count reaches zero, the channel goes idle, and `st_end` becomes 1 if command bit 21 is 1. A count of zero at load ends the transfer at once, with no bus beat.
- R10: `dreq` has no effect while the channel is idle, that is, while no bytes remain.
- R11: Flags are sticky. `clr[0]` clears `st_start`, `clr[1]` clears `st_end` and `clr[2]` clears `st_err`. If a flag is set and cleared in the same cycle, the set wins. `irq` is the OR of the three flags.
- R12: Command bits 27:23 are reserved and have no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Channel can accept a descriptor |
| desc_cmd | input | 32 | Command word (count in 12:0) |
| desc_src | input | AW | Source start address |
| desc_trg | input | AW | Target start address |
| dreq | input | 1 | Peripheral pacing request |
| bus_req | output | 1 | Bus beat request |
| bus_we | output | 1 | 1 = write beat, 0 = read beat |
| bus_addr | output | AW | Beat address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, taken with `bus_ack` |
| bus_ack | input | 1 | Beat completes on this edge |
| busy | output | 1 | Transfer in progress |
| clr | input | 3 | Write-1-to-clear: bit0 start, bit1 end, bit2 error |
| st_start | output | 1 | Descriptor-accepted flag |
| st_end | output | 1 | Transfer-finished flag |
| st_err | output | 1 | Illegal-command flag |
| irq | output | 1 | OR of the flags |

## Verification
The end flag can be set on the same edge where software clears it. That edge is the write ack that consumes the final bytes. The bench provokes this by holding `clr[1]` high for the whole final write beat, so the clear lands on that ack edge whatever the ack latency. It then checks that `st_end` reads 1 afterwards. A behavioural model predicts every output on every cycle, so a wrong priority or a one-cycle shift shows up at once.

// File: rtl/dma_cmd_channel.sv
module dma_cmd_channel #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          desc_valid,
  output logic          desc_ready,
  input  logic [31:0]   desc_cmd,
  input  logic [AW-1:0] desc_src,
  input  logic [AW-1:0] desc_trg,
  input  logic          dreq,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ack,
  output logic          busy,
  input  logic [2:0]    clr,
  output logic          st_start,
  output logic          st_end,
  output logic          st_err,
  output logic          irq
);
  localparam int BEAT = DW / 8;
  localparam logic [LW-1:0] BEAT_L = LW'(BEAT);
  localparam logic [AW-1:0] BEAT_A = AW'(BEAT);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RD, S_WR} state_t;

  state_t        st;
  logic          inc_s, inc_t, paced, end_en;
  logic [AW-1:0] src, trg;
  logic [LW-1:0] len;
  logic [DW-1:0] hold;

  wire acc      = desc_valid & desc_ready;
  wire bad      = desc_cmd[29] & desc_cmd[28];
  wire good_acc = acc & ~bad;
  wire zero_ld  = desc_cmd[LW-1:0] == '0;
  wire wr_done  = (st == S_WR) & bus_ack;
  wire last     = wr_done & (len <= BEAT_L);

  wire set_start = good_acc & desc_cmd[22];
  wire set_end   = (good_acc & zero_ld & desc_cmd[21]) | (last & end_en);
  wire set_err   = acc & bad;

  assign desc_ready = st == S_IDLE;
  assign busy       = st != S_IDLE;
  assign bus_req    = (st == S_RD) | (st == S_WR);
  assign bus_we     = st == S_WR;
  assign bus_addr   = (st == S_WR) ? trg : src;
  assign bus_wdata  = hold;
  assign irq        = st_start | st_end | st_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      inc_s <= 1'b0; inc_t <= 1'b0; paced <= 1'b0; end_en <= 1'b0;
      src <= '0; trg <= '0; len <= '0; hold <= '0;
      st_start <= 1'b0; st_end <= 1'b0; st_err <= 1'b0;
    end else begin
      st_start <= (st_start & ~clr[0]) | set_start;
      st_end   <= (st_end   & ~clr[1]) | set_end;
      st_err   <= (st_err   & ~clr[2]) | set_err;
      unique case (st)
        S_IDLE: if (good_acc) begin
          inc_s  <= desc_cmd[31];
          inc_t  <= desc_cmd[30];
          paced  <= desc_cmd[29] | desc_cmd[28];
          end_en <= desc_cmd[21];
          src    <= desc_src;
          trg    <= desc_trg;
          len    <= desc_cmd[LW-1:0];
          st     <= zero_ld ? S_IDLE : S_WAIT;
        end
        S_WAIT: if (!paced || dreq) st <= S_RD;
        S_RD: if (bus_ack) begin
          hold <= bus_rdata;
          st   <= S_WR;
        end
        S_WR: if (bus_ack) begin
          if (inc_s) src <= src + BEAT_A;
          if (inc_t) trg <= trg + BEAT_A;
          len <= last ? '0 : len - BEAT_L;
          st  <= last ? S_IDLE : S_WAIT;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module dma_cmd_channel_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          desc_valid,
  input logic          desc_ready,
  input logic [31:0]   desc_cmd,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          bus_ack,
  input logic          busy,
  input logic [2:0]    clr,
  input logic          st_start,
  input logic          st_end
);
  p_rd_then_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we && bus_ack |=> bus_req && bus_we);
  p_wr_releases_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_ack |=> !bus_req);
  p_hold_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we));
  p_illegal_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_ready && desc_cmd[29] && desc_cmd[28] |=> !busy);
  p_start_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_ready && !(desc_cmd[29] && desc_cmd[28]) && desc_cmd[22] |=> st_start);
  p_end_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    st_end && !clr[1] |=> st_end);
  p_busy_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !desc_ready);
endmodule

bind dma_cmd_channel dma_cmd_channel_chk #(.AW(AW), .DW(DW), .LW(LW)) u_chk (.*);

// File: tb/dma_cmd_channel_bench.sv
module dma_cmd_channel_bench;
  localparam int AW = 32, DW = 32, LW = 13, BEAT = DW / 8;
  localparam logic [31:0] MASK = 32'h5A5A_0000;

  logic clk = 0, rst_n = 0;
  logic desc_valid = 0, dreq = 0, bus_ack = 0;
  logic [31:0] desc_cmd = 0;
  logic [AW-1:0] desc_src = 0, desc_trg = 0;
  logic [2:0] clr = 0;
  logic desc_ready, bus_req, bus_we, busy, st_start, st_end, st_err, irq;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  always #10 clk = ~clk;
  assign bus_rdata = bus_addr ^ MASK;

  dma_cmd_channel #(.AW(AW), .DW(DW), .LW(LW)) u_dma_cmd_channel (.*);

  int total = 0, bad = 0, cyc = 0, wr_seen = 0, ack_ctr = 0;
  bit ack_slow = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 wait, 2 read, 3 write
  int m_phase = 0;
  bit m_is, m_it, m_pace, m_ee, f_s, f_e, f_r;
  longint m_src, m_trg, m_len, m_buf;

  always @(posedge clk) begin
    bit ss, se, sr;
    if (!rst_n) begin
      m_phase = 0; f_s = 0; f_e = 0; f_r = 0; m_buf = 0; m_src = 0; m_trg = 0; m_len = 0;
    end else begin
      ss = 0; se = 0; sr = 0;
      case (m_phase)
        0: if (desc_valid) begin
          if (desc_cmd[29] && desc_cmd[28]) sr = 1;
          else begin
            m_is = desc_cmd[31]; m_it = desc_cmd[30];
            m_pace = desc_cmd[29] || desc_cmd[28]; m_ee = desc_cmd[21];
            m_src = desc_src; m_trg = desc_trg; m_len = desc_cmd[12:0];
            ss = desc_cmd[22];
            if (m_len == 0) se = desc_cmd[21]; else m_phase = 1;
          end
        end
        1: if (!m_pace || dreq) m_phase = 2;
        2: if (bus_ack) begin m_buf = (m_src ^ MASK) & 32'hFFFF_FFFF; m_phase = 3; end
        3: if (bus_ack) begin
          if (m_is) m_src = (m_src + BEAT) & 32'hFFFF_FFFF;
          if (m_it) m_trg = (m_trg + BEAT) & 32'hFFFF_FFFF;
          if (m_len <= BEAT) begin m_len = 0; se = m_ee; m_phase = 0; end
          else begin m_len -= BEAT; m_phase = 1; end
        end
        default: m_phase = 0;
      endcase
      f_s = (f_s && !clr[0]) || ss;
      f_e = (f_e && !clr[1]) || se;
      f_r = (f_r && !clr[2]) || sr;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(busy == (m_phase != 0), "R2 busy", busy, m_phase != 0);
      chk(desc_ready == (m_phase == 0), "R2 desc_ready", desc_ready, m_phase == 0);
      chk(bus_req == (m_phase >= 2), "R6/R10 bus_req", bus_req, m_phase >= 2);
      if (m_phase >= 2) begin
        chk(bus_we == (m_phase == 3), "R5 bus_we", bus_we, m_phase == 3);
        chk(bus_addr == (m_phase == 3 ? m_trg : m_src), "R3/R4 bus_addr", bus_addr,
            m_phase == 3 ? m_trg : m_src);
      end
      if (m_phase == 3) chk(bus_wdata == m_buf, "R5 bus_wdata", bus_wdata, m_buf);
      chk(st_start == f_s, "R8 st_start", st_start, f_s);
      chk(st_end == f_e, "R9 st_end", st_end, f_e);
      chk(st_err == f_r, "R7 st_err", st_err, f_r);
      chk(irq == (f_s || f_e || f_r), "R11 irq", irq, f_s || f_e || f_r);
    end
    ack_ctr++;
    bus_ack <= bus_req && (ack_slow ? (ack_ctr % 4 == 0) : (ack_ctr % 3 != 0));
    if (bus_req && bus_we && (ack_slow ? (ack_ctr % 4 == 0) : (ack_ctr % 3 != 0))) wr_seen++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog expired act=%0d exp=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic load(input logic [31:0] cmd, input logic [31:0] s, input logic [31:0] t);
    @(negedge clk);
    while (!desc_ready) @(negedge clk);
    desc_valid = 1; desc_cmd = cmd; desc_src = s; desc_trg = t;
    @(negedge clk);
    desc_valid = 0; desc_cmd = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic clear_all();
    clr = 3'b111; @(negedge clk); clr = 0;
  endtask

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && desc_ready == 1 && bus_req == 0, "R1 idle after reset", busy, 0);
    chk({st_start, st_end, st_err, irq} == 0, "R1 flags clear", {st_start, st_end, st_err, irq}, 0);
    rst_n = 1;

    // R3 R4 R12: both addresses step, reserved bits set, no pacing
    w0 = wr_seen;
    load(32'hC060_0000 | (5'h1F << 23) | 16, 32'h1000, 32'h2000);
    wait_idle();
    chk(wr_seen - w0 == 4, "R9/R12 write count", wr_seen - w0, 4);
    chk(st_start && st_end, "R8/R9 flags after run", {st_start, st_end}, 2'b11);
    clear_all();

    // R6: source pacing, fixed source, stepping target, toggling dreq
    w0 = wr_seen;
    fork
      load(32'h6020_0000 | 12, 32'h3000, 32'h4000);
      repeat (120) begin @(negedge clk); dreq = ~dreq; end
    join
    dreq = 0; wait_idle();
    chk(wr_seen - w0 == 3, "R3/R6 paced write count", wr_seen - w0, 3);
    clear_all();

    // R6: target pacing held off, then released; R10 no beat while dreq low
    w0 = wr_seen; ack_slow = 1;
    load(32'h9020_0000 | 8, 32'h5000, 32'h6000);
    repeat (10) @(negedge clk);
    chk(bus_req == 0 && busy == 1, "R6 waits for dreq", bus_req, 0);
    dreq = 1; wait_idle(); dreq = 0; ack_slow = 0;
    chk(wr_seen - w0 == 2, "R4/R6 target paced count", wr_seen - w0, 2);
    clear_all();

    // R7: both pacing bits
    w0 = wr_seen;
    load(32'hF060_0000 | 16, 32'h7000, 32'h8000);
    repeat (4) @(negedge clk);
    chk(st_err == 1 && busy == 0 && st_start == 0, "R7 illegal command", {st_err, busy, st_start}, 3'b100);
    chk(wr_seen == w0, "R7 no writes", wr_seen - w0, 0);
    clear_all();

    // R9: zero length ends at once
    load(32'h0060_0000, 32'h9000, 32'hA000);
    @(negedge clk);
    chk(busy == 0 && st_start && st_end, "R9 zero length", {busy, st_start, st_end}, 3'b011);
    clear_all();

    // R10: dreq pulses while idle
    w0 = wr_seen;
    repeat (6) begin dreq = 1; @(negedge clk); chk(bus_req == 0, "R10 idle dreq", bus_req, 0); dreq = 0; end
    chk(wr_seen == w0 && busy == 0, "R10 no activity", wr_seen - w0, 0);

    // R11: clear coincides with end set; set wins
    load(32'h0020_0000 | 4, 32'hB000, 32'hC000);
    while (busy) begin
      clr[1] = (m_phase == 3);
      @(negedge clk);
    end
    clr = 0;
    chk(st_end == 1 && irq == 1, "R11 set beats clear", st_end, 1);
    clr = 3'b010; @(negedge clk); clr = 0;
    chk(st_end == 0 && irq == 0, "R11 clear works", st_end, 0);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule